// File: doc/BRIEF.md
# Printer-Port Style Digital I/O Register Block

This block is a bus slave with the register set of a legacy printer parallel port. Software uses it as a small general digital I/O unit. Three byte registers sit at offsets 0, 1 and 2 of a two-bit offset bus:

- **Offset 0, output latch.** It drives eight output pins.
- **Offset 1, status view.** It is read-only and shows five sense pins.
- **Offset 2, control register.** It drives four lines and holds an interrupt enable.

The four control lines behave as open-collector outputs. Writing the released level lets an outside driver pull a line low, and the readback then shows the real line level. So the lines can also be used as inputs.

Several bits carry a fixed polarity inversion between register and pin, both when written and when read. The acknowledge sense pin raises a level interrupt request while the enable bit is set. Every external input passes through a two-flop synchronizer before it is used. A read strobe loads the read data register on the next clock edge.

Top module: `lpt_port_regs`

## Requirements
- R1: A write at offset 0 drives the byte on `data_o` after the clock edge, and `data_o` holds that value until offset 0 is written again.
- R2: A read at offset 0 returns the last byte written there, whatever the sense and control pins are doing. Read data appears on `rdata_o` one edge after `rd_i`.
- R3: In the status byte (offset 1), bits 3, 4, 5 and 6 show `sense_i[0]`, `sense_i[1]`, `sense_i[2]` and `sense_i[3]` (the acknowledge pin) without inversion. Bits 2..0 read 0.
- R4: Status bit 7 shows `sense_i[4]` inverted. Writes to offset 1 change nothing.
- R5: The control register sets the driven level of each control line. `ctl_pin_o` bits 0, 1 and 3 are the inverse of control bits 0, 1 and 3, and `ctl_pin_o[2]` equals control bit 2. A 1 on `ctl_pin_o` means the line is released.
- R6: Control readback bits 3..0 equal the line level, `ctl_pin_o & ctl_ext_i`, with the same per-bit inversion as R5 applied. Bit 4 reads back the interrupt enable, and bits 7..5 read 0 whatever is written.
- R7: `irq_o` is high exactly while the synchronized `sense_i[3]` is high and control bit 4 is set. Clearing the enable drops `irq_o` on the next edge.
- R8: After reset, `data_o` is 0x00 and the control register is 0x00. This gives `ctl_pin_o` = 4'b1011 and `irq_o` low.
- R9: Offset 3 reads as 0x00, and a write there changes neither the data nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, loaded one edge after rd_i |
| data_o | output | 8 | Output latch pins |
| sense_i | input | 5 | Sense pins: [0..2] true-high inputs, [3] acknowledge, [4] inverted busy |
| ctl_pin_o | output | 4 | Open-collector drive level of the control lines (1 = released) |
| ctl_ext_i | input | 4 | External level on the control lines (0 = pulled low) |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench runs a set of sense patterns through the status byte. A design that dropped the busy-bit inversion, or that shifted the field, would give wrong bytes on the mixed patterns.

On the control lines, the bench releases a line and pulls it low from outside, and it also pulls down a line that the block itself drives. A design that read back its own register instead of the wired-AND level would miss the external pull. A design that inverted the readback wrongly would report released lines as asserted.

The bench also checks these cases:
- Writes to the read-only and unused offsets, where a loose decoder would corrupt the data or control register.
- Reserved control bits written as 1, which must still read 0.
- The interrupt with the enable set and clear, where a design that ignored the gate would raise `irq_o` spuriously.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 2;
  localparam int unsigned N_SENSE = 5;
  localparam int unsigned N_CTL   = 4;

  localparam logic [AW-1:0] OFF_DATA = 2'd0;
  localparam logic [AW-1:0] OFF_STAT = 2'd1;
  localparam logic [AW-1:0] OFF_CTRL = 2'd2;

  // control lines whose register bit is the inverse of the pin level
  localparam logic [N_CTL-1:0] CTL_INV = 4'b1011;
  localparam int unsigned      IEN_BIT = N_CTL;
  localparam int unsigned      ACK_IDX = 3;
  localparam int unsigned      BSY_IDX = 4;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lpt_status_map.sv
module lpt_status_map
  import lpt_pkg::*;
(
  input  logic [N_SENSE-1:0] sense_s_i,
  output logic [DW-1:0]      status_o
);
  localparam int unsigned LOW_RSV = DW - N_SENSE;

  always_comb begin
    status_o = '0;
    for (int i = 0; i < N_SENSE; i++) begin
      status_o[LOW_RSV + i] = (i == BSY_IDX) ? ~sense_s_i[i] : sense_s_i[i];
    end
  end
endmodule

// File: rtl/lpt_ctl_lines.sv
module lpt_ctl_lines
  import lpt_pkg::*;
(
  input  logic [N_CTL-1:0] ctl_bits_i,
  input  logic [N_CTL-1:0] ext_s_i,
  output logic [N_CTL-1:0] drive_o,
  output logic [N_CTL-1:0] readback_o
);
  logic [N_CTL-1:0] line_lvl;

  for (genvar g = 0; g < N_CTL; g++) begin : g_line
    if (CTL_INV[g]) begin : g_inv
      assign drive_o[g]    = ~ctl_bits_i[g];
      assign readback_o[g] = ~line_lvl[g];
    end else begin : g_dir
      assign drive_o[g]    = ctl_bits_i[g];
      assign readback_o[g] = line_lvl[g];
    end
    // open-collector: line is low if either side pulls it low
    assign line_lvl[g] = drive_o[g] & ext_s_i[g];
  end
endmodule

// File: rtl/lpt_port_regs.sv
module lpt_port_regs
  import lpt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [DW-1:0]      data_o,
  input  logic [N_SENSE-1:0] sense_i,
  output logic [N_CTL-1:0]   ctl_pin_o,
  input  logic [N_CTL-1:0]   ctl_ext_i,
  output logic               irq_o
);
  localparam int unsigned CW = N_CTL + 1;

  logic [DW-1:0]      data_q;
  logic [CW-1:0]      ctrl_q;
  logic [DW-1:0]      rdata_q;
  logic [N_SENSE-1:0] sense_s;
  logic [N_CTL-1:0]   ext_s;
  logic [N_CTL-1:0]   ctl_rb;
  logic [DW-1:0]      status;
  logic [DW-1:0]      rd_mux;

  lpt_sync #(.W(N_SENSE)) u_sync_sense (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sense_i), .q_o(sense_s)
  );

  lpt_sync #(.W(N_CTL)) u_sync_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctl_ext_i), .q_o(ext_s)
  );

  lpt_status_map u_status (
    .sense_s_i(sense_s), .status_o(status)
  );

  lpt_ctl_lines u_ctl (
    .ctl_bits_i(ctrl_q[N_CTL-1:0]),
    .ext_s_i   (ext_s),
    .drive_o   (ctl_pin_o),
    .readback_o(ctl_rb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      if (addr_i == OFF_DATA) data_q <= wdata_i;
      if (addr_i == OFF_CTRL) ctrl_q <= wdata_i[CW-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFF_DATA: rd_mux = data_q;
      OFF_STAT: rd_mux = status;
      OFF_CTRL: rd_mux = {{(DW-CW){1'b0}}, ctrl_q[IEN_BIT], ctl_rb};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign data_o  = data_q;
  assign irq_o   = sense_s[ACK_IDX] & ctrl_q[IEN_BIT];

  // R1
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == OFF_DATA) |=> $stable(data_o));
  // R2
  data_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == OFF_DATA) |=> rdata_o == data_o);
  // R3
  stat_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_STAT) |=> rdata_o[2:0] == 3'b000);
  // R5
  ctl_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_CTRL) |=> ctl_pin_o == ($past(wdata_i[N_CTL-1:0]) ^ CTL_INV));
  // R6
  ctl_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_CTRL) |=> rdata_o[DW-1:CW] == '0);
  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_CTRL && !wdata_i[IEN_BIT]) |=> !irq_o);
  // R9
  unused_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3) |=> rdata_o == '0);
endmodule

// File: tb/lpt_port_regs_tb.sv
module lpt_port_regs_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, data;
  logic [4:0] sense = 0;
  logic [3:0] ctl_pin;
  logic [3:0] ctl_ext = 4'hF;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpt_port_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .data_o(data), .sense_i(sense),
    .ctl_pin_o(ctl_pin), .ctl_ext_i(ctl_ext), .irq_o(irq)
  );

  // {sense[4:0], expected status byte}
  localparam logic [12:0] STAT_VEC [6] = '{
    {5'b00000, 8'h80}, {5'b11111, 8'h78}, {5'b00001, 8'h88},
    {5'b10000, 8'h00}, {5'b01010, 8'hD0}, {5'b10101, 8'h28}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R8 reset state
    chk("R8 data_o", data, 8'h00);
    chk("R8 ctl_pin_o", {4'h0, ctl_pin}, 8'h0B);
    chk("R8 irq_o", {7'h0, irq}, 8'h00);
    bus_rd(2'd2, r); chk("R8 ctrl read", r, 8'h00);

    // R3 R4 status vectors
    for (int i = 0; i < 6; i++) begin
      sense = STAT_VEC[i][12:8];
      settle();
      bus_rd(2'd1, r);
      chk("R3/R4 status", r, STAT_VEC[i][7:0]);
      chk("R7 irq disabled", {7'h0, irq}, 8'h00);
    end

    // R1 R2
    sense = 5'b11111;
    bus_wr(2'd0, 8'hA5);
    chk("R1 data_o", data, 8'hA5);
    bus_rd(2'd0, r); chk("R2 data read", r, 8'hA5);
    repeat (5) @(negedge clk);
    chk("R1 data hold", data, 8'hA5);

    // R4 write to status ignored
    bus_wr(2'd1, 8'hFF);
    chk("R4 status write data_o", data, 8'hA5);
    bus_rd(2'd1, r); chk("R4 status after write", r, 8'h78);
    bus_rd(2'd2, r); chk("R4 ctrl after status write", r, 8'h00);

    // R5 R6 control
    bus_wr(2'd2, 8'hFF);
    chk("R5 drive all set", {4'h0, ctl_pin}, 8'h04);
    settle();
    bus_rd(2'd2, r); chk("R6 reserved bits", r, 8'h1F);

    bus_wr(2'd2, 8'h10);
    ctl_ext = 4'b0110;
    settle();
    chk("R5 drive released", {4'h0, ctl_pin}, 8'h0B);
    bus_rd(2'd2, r); chk("R6 external pull", r, 8'h19);

    bus_wr(2'd2, 8'h14);
    ctl_ext = 4'b1111;
    settle();
    bus_rd(2'd2, r); chk("R6 direct bit high", r, 8'h14);
    ctl_ext = 4'b1011;
    settle();
    bus_rd(2'd2, r); chk("R6 direct bit pulled", r, 8'h10);
    ctl_ext = 4'hF;

    // R7 irq
    sense = 5'b01000;
    settle();
    chk("R7 irq on", {7'h0, irq}, 8'h01);
    sense = 5'b00000;
    settle();
    chk("R7 irq ack low", {7'h0, irq}, 8'h00);
    sense = 5'b01000;
    settle();
    bus_wr(2'd2, 8'h00);
    chk("R7 irq disabled", {7'h0, irq}, 8'h00);

    // R9 unused offset
    bus_wr(2'd2, 8'h13);
    bus_wr(2'd3, 8'h5A);
    bus_rd(2'd3, r); chk("R9 offset 3 read", r, 8'h00);
    chk("R9 data unchanged", data, 8'hA5);
    settle();
    bus_rd(2'd2, r); chk("R9 ctrl unchanged", r, 8'h13);

    finish_sim();
  end
endmodule